// File: doc/BRIEF.md
# LCD Common/Segment Scan Controller

This block produces the digital scan timing for a multiplexed dot-matrix LCD with 64 segment lines and up to 32 common lines. It steps through the common lines one at a time. While a common is selected it presents that row's 64 segment bits, read from an internal display buffer. It also produces a polarity signal that flips every frame, so the analog driver stage that follows can keep DC bias off the glass. Bias voltages, the charge pump and the regulator are outside this block. Its outputs are the logic-level common index, the row data, the polarity and the pin-sharing enables.

The buffer holds two full-screen pages of 512 four-bit words. The host writes it one nibble at a time. Row r of a page occupies word addresses r*16 to r*16+15. Word k of a row carries segments 4k to 4k+3, with bit i of the word driving segment 4k+i. The clock is the 32.768 kHz scan clock. Each common is held for 2*(rate+1) clocks, so with the default rate code 0111b a 32-row frame takes 512 clocks, which gives 64 Hz. A 1/16 duty mode scans commons 0 to 15 only. In that mode the upper eight commons may be given up to general I/O. Segments 40 to 63 can be given up in six groups of four.

Top module: `lcd_scan_ctrl`

## Requirements
- R1: While reset is low, and on the first clock after it, com_idx is 0, polarity is 0, and page 0 is shown in 1/32 duty. Every buffer word is cleared, so row_seg is 0.
- R2: Each common index is held for exactly 2*(rate_sel+1) clock cycles. With rate_sel = 0111b this is 16 cycles, and one 1/32 frame lasts 512 cycles.
- R3: In 1/32 duty com_idx steps 0,1,...,31 and then returns to 0. In 1/16 duty it steps 0,...,15 and then returns to 0.
- R4: polarity inverts exactly once per frame, on the clock at which com_idx returns to 0, and at no other time.
- R5: row_seg bit 4k+i equals bit i of the word at address com_idx*16+k of the page being shown, for k in 0..15 and i in 0..3.
- R6: A write with wr_en high stores wr_data at wr_addr of page wr_page only. It becomes visible on row_seg from the next cycle if that page and row are being shown. The other page is left unchanged.
- R7: page_sel and duty_sel are sampled only at the frame boundary (the clock at which com_idx returns to 0). A change in the middle of a frame does not alter the shown page or the scan length until that boundary.
- R8: seg_release[g] (g in 0..5) drives seg_lcd_en[g] to 0 and forces row_seg bits 40+4g to 43+4g to 0. When seg_release[g] is 0, seg_lcd_en[g] is 1 and those bits follow R5.
- R9: com_hi_lcd is 0 (commons 24 to 31 given up to general I/O) only when com_release is 1 and the duty in effect is 1/16. Otherwise com_hi_lcd is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scan clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Buffer write strobe |
| wr_page | input | 1 | Page written by the strobe |
| wr_addr | input | 9 | Word address: row in bits 8:4, word within the row in bits 3:0 |
| wr_data | input | 4 | Nibble to store |
| duty_sel | input | 1 | 0 = 1/32 duty, 1 = 1/16 duty (taken at frame boundary) |
| rate_sel | input | 4 | Frame-rate code; rows last 2*(code+1) clocks |
| page_sel | input | 1 | Page to show (taken at frame boundary) |
| seg_release | input | 6 | Release request per four-segment group starting at segment 40 |
| com_release | input | 1 | Release request for commons 24 to 31 |
| com_idx | output | 5 | Index of the common being driven |
| row_seg | output | 64 | Segment bits of the current row |
| polarity | output | 1 | Frame inversion polarity |
| seg_lcd_en | output | 6 | 1 = segment group works as segment output |
| com_hi_lcd | output | 1 | 1 = commons 24 to 31 work as commons |

## Verification
The bench goes after the frame boundary. A page or duty change that lands in the middle of a frame must wait. A design that applied it at once would show a torn image, or would jump com_idx out of the 0 to 15 range. The bench measures the hold time at the smallest, the default and the largest rate codes. An off-by-one divider would show 15 or 17 clocks where 16 are expected. It writes to the hidden page while the other page is shown, to catch a page decode that leaks across pages. It also toggles the release inputs in both duty modes. Releasing the upper commons in 1/32 duty must have no effect, and a released segment group must read as zero.

// File: rtl/lcd_scan_pkg.sv
// Package: shared geometry of the LCD scan controller.
// Assumes a panel whose segment count is a multiple of the nibble width.
package lcd_scan_pkg;
    localparam int unsigned LCD_ROWS     = 32;  // commons scanned in full duty
    localparam int unsigned LCD_SEGS     = 64;  // segment lines per row
    localparam int unsigned LCD_NIB      = 4;   // bits per buffer word
    localparam int unsigned LCD_RATE_W   = 4;   // width of the frame-rate code
    localparam int unsigned LCD_SHARE_LO = 40;  // first shareable segment
endpackage

// File: rtl/lcd_scan_timer.sv
// Module: lcd_scan_timer
// Divides the scan clock into row slots, steps the common index, flips the
// frame polarity and latches page and duty at each frame boundary.
// Assumes ROWS is even; half duty scans the lower ROWS/2 commons.
module lcd_scan_timer #(
    parameter int unsigned ROWS   = 32,
    parameter int unsigned RATE_W = 4,
    localparam int unsigned ROW_W = $clog2(ROWS),
    localparam int unsigned DIV_W = RATE_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             duty_sel,
    input  logic             page_sel,
    input  logic [RATE_W-1:0] rate_sel,
    output logic [ROW_W-1:0] row,
    output logic             polarity,
    output logic             cur_page,
    output logic             cur_half
);
    logic [DIV_W-1:0] div_cnt;
    logic [DIV_W-1:0] hold_last;
    logic [ROW_W-1:0] last_row;

    // Last divider count of a row slot and last common of a frame.
    always_comb begin
        hold_last = {rate_sel, 1'b1};
        last_row  = cur_half ? ROW_W'(ROWS / 2 - 1) : ROW_W'(ROWS - 1);
    end

    // Row slot divider, common stepping and frame boundary latching.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_cnt  <= '0;
            row      <= '0;
            polarity <= 1'b0;
            cur_page <= 1'b0;
            cur_half <= 1'b0;
        end else if (div_cnt >= hold_last) begin
            div_cnt <= '0;
            if (row == last_row) begin
                row      <= '0;
                polarity <= ~polarity;
                cur_page <= page_sel;
                cur_half <= duty_sel;
            end else begin
                row <= row + 1'b1;
            end
        end else begin
            div_cnt <= div_cnt + 1'b1;
        end
    end

    AST_ROW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (div_cnt != '0) |-> $stable(row)); // R2
    AST_POL_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(polarity) |-> (row == '0 && div_cnt == '0)); // R4
    AST_HALF_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cur_half |-> (row < ROW_W'(ROWS / 2))); // R3
    AST_PAGE_AT_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cur_page) |-> (row == '0 && div_cnt == '0)); // R7
endmodule

// File: rtl/lcd_page_buf.sv
// Module: lcd_page_buf
// Two-page display store written in nibbles and read one full row at a time.
// Assumes the word address is {row, word-in-row}; cleared on reset.
module lcd_page_buf #(
    parameter int unsigned ROWS = 32,
    parameter int unsigned SEGS = 64,
    parameter int unsigned NIB  = 4,
    localparam int unsigned ROW_W  = $clog2(ROWS),
    localparam int unsigned COL_W  = $clog2(SEGS / NIB),
    localparam int unsigned ADDR_W = ROW_W + COL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_page,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [NIB-1:0]    wr_data,
    input  logic              rd_page,
    input  logic [ROW_W-1:0]  rd_row,
    output logic [SEGS-1:0]   rd_data
);
    logic [SEGS-1:0] store [2][ROWS];

    // Clear on reset, otherwise merge one nibble into its row word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int p = 0; p < 2; p++) begin
                for (int r = 0; r < ROWS; r++) begin
                    store[p][r] <= '0;
                end
            end
        end else if (wr_en) begin
            store[wr_page][wr_addr[ADDR_W-1:COL_W]][int'(wr_addr[COL_W-1:0]) * NIB +: NIB] <= wr_data;
        end
    end

    // Whole-row read of the shown page.
    always_comb rd_data = store[rd_page][rd_row];
endmodule

// File: rtl/lcd_pin_share.sv
// Module: lcd_pin_share
// Applies pin-sharing requests: released segment groups read as zero and
// drop their enable; upper commons are released only in half duty.
// Assumes shareable segments start on a nibble boundary and run to the top.
module lcd_pin_share #(
    parameter int unsigned SEGS     = 64,
    parameter int unsigned NIB      = 4,
    parameter int unsigned SHARE_LO = 40,
    localparam int unsigned GROUPS  = (SEGS - SHARE_LO) / NIB
) (
    input  logic [SEGS-1:0]   raw_row,
    input  logic [GROUPS-1:0] seg_release,
    input  logic              com_release,
    input  logic              half_duty,
    output logic [SEGS-1:0]   row_out,
    output logic [GROUPS-1:0] seg_lcd_en,
    output logic              com_hi_lcd
);
    // One lane per nibble; lanes above SHARE_LO may be masked.
    for (genvar g = 0; g < SEGS / NIB; g++) begin : g_lane
        if (g * NIB >= SHARE_LO) begin : g_shared
            assign row_out[g*NIB +: NIB] =
                seg_release[(g*NIB - SHARE_LO) / NIB] ? '0 : raw_row[g*NIB +: NIB];
        end else begin : g_fixed
            assign row_out[g*NIB +: NIB] = raw_row[g*NIB +: NIB];
        end
    end

    // Function enables of the shared pins.
    always_comb begin
        seg_lcd_en = ~seg_release;
        com_hi_lcd = ~(com_release & half_duty);
    end
endmodule

// File: rtl/lcd_scan_ctrl.sv
// Module: lcd_scan_ctrl (top)
// Scan controller for a multiplexed LCD: timer, two-page buffer and pin
// sharing. Assumes clk is the scan clock; outputs are logic level only.
module lcd_scan_ctrl
    import lcd_scan_pkg::*;
#(
    parameter int unsigned ROWS     = LCD_ROWS,
    parameter int unsigned SEGS     = LCD_SEGS,
    parameter int unsigned NIB      = LCD_NIB,
    parameter int unsigned RATE_W   = LCD_RATE_W,
    parameter int unsigned SHARE_LO = LCD_SHARE_LO,
    localparam int unsigned ROW_W   = $clog2(ROWS),
    localparam int unsigned ADDR_W  = ROW_W + $clog2(SEGS / NIB),
    localparam int unsigned GROUPS  = (SEGS - SHARE_LO) / NIB
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_page,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [NIB-1:0]    wr_data,
    input  logic              duty_sel,
    input  logic [RATE_W-1:0] rate_sel,
    input  logic              page_sel,
    input  logic [GROUPS-1:0] seg_release,
    input  logic              com_release,
    output logic [ROW_W-1:0]  com_idx,
    output logic [SEGS-1:0]   row_seg,
    output logic              polarity,
    output logic [GROUPS-1:0] seg_lcd_en,
    output logic              com_hi_lcd
);
    logic            shown_page;
    logic            half_duty;
    logic [SEGS-1:0] raw_row;

    lcd_scan_timer #(.ROWS(ROWS), .RATE_W(RATE_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .duty_sel(duty_sel), .page_sel(page_sel),
        .rate_sel(rate_sel), .row(com_idx), .polarity(polarity),
        .cur_page(shown_page), .cur_half(half_duty)
    );

    lcd_page_buf #(.ROWS(ROWS), .SEGS(SEGS), .NIB(NIB)) u_buf (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_page(wr_page),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_page(shown_page),
        .rd_row(com_idx), .rd_data(raw_row)
    );

    lcd_pin_share #(.SEGS(SEGS), .NIB(NIB), .SHARE_LO(SHARE_LO)) u_share (
        .raw_row(raw_row), .seg_release(seg_release), .com_release(com_release),
        .half_duty(half_duty), .row_out(row_seg), .seg_lcd_en(seg_lcd_en),
        .com_hi_lcd(com_hi_lcd)
    );

    AST_COM_HI_SCAN: assert property (@(posedge clk) disable iff (!rst_n)
        !com_hi_lcd |-> (com_idx < ROW_W'(ROWS / 2))); // R9
endmodule

// File: tb/tb_lcd_scan_ctrl.sv
module tb_lcd_scan_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_page = 1'b0;
    logic [8:0]  wr_addr = '0;
    logic [3:0]  wr_data = '0;
    logic        duty_sel = 1'b0;
    logic [3:0]  rate_sel = 4'd7;
    logic        page_sel = 1'b0;
    logic [5:0]  seg_release = '0;
    logic        com_release = 1'b0;
    logic [4:0]  com_idx;
    logic [63:0] row_seg;
    logic        polarity;
    logic [5:0]  seg_lcd_en;
    logic        com_hi_lcd;

    int checks = 0;
    int errors = 0;

    // Reference state built from the requirements.
    logic [63:0] model [2][32];
    int          m_div = 0;
    int          m_row = 0;
    logic        m_pol = 1'b0;
    logic        m_page = 1'b0;
    logic        m_half = 1'b0;

    lcd_scan_ctrl dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_page(wr_page),
        .wr_addr(wr_addr), .wr_data(wr_data), .duty_sel(duty_sel),
        .rate_sel(rate_sel), .page_sel(page_sel), .seg_release(seg_release),
        .com_release(com_release), .com_idx(com_idx), .row_seg(row_seg),
        .polarity(polarity), .seg_lcd_en(seg_lcd_en), .com_hi_lcd(com_hi_lcd)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] exp_row(input logic pg, input int r,
                                            input logic [5:0] rel);
        logic [63:0] d;
        d = model[pg][r];
        for (int g = 0; g < 6; g++) if (rel[g]) d[40 + 4*g +: 4] = 4'h0;
        return d;
    endfunction

    // Advance the reference by one clock using the inputs held at the edge.
    task automatic model_step();
        if (!rst_n) begin
            m_div = 0; m_row = 0; m_pol = 1'b0; m_page = 1'b0; m_half = 1'b0;
            for (int p = 0; p < 2; p++) for (int r = 0; r < 32; r++) model[p][r] = '0;
        end else begin
            if (wr_en) model[wr_page][wr_addr[8:4]][int'(wr_addr[3:0])*4 +: 4] = wr_data;
            if (m_div >= 2*int'(rate_sel) + 1) begin
                m_div = 0;
                if (m_row == (m_half ? 15 : 31)) begin
                    m_row = 0; m_pol = ~m_pol; m_page = page_sel; m_half = duty_sel;
                end else m_row++;
            end else m_div++;
        end
    endtask

    task automatic check_all();
        chk(com_idx == 5'(m_row), "R3 com_idx", 64'(com_idx), 64'(m_row));
        chk(polarity == m_pol, "R4 polarity", 64'(polarity), 64'(m_pol));
        chk(row_seg == exp_row(m_page, m_row, seg_release), "R5 R6 R7 R8 row_seg",
            row_seg, exp_row(m_page, m_row, seg_release));
        chk(seg_lcd_en == ~seg_release, "R8 seg_lcd_en", 64'(seg_lcd_en), 64'(~seg_release));
        chk(com_hi_lcd == !(com_release && m_half), "R9 com_hi_lcd",
            64'(com_hi_lcd), 64'(!(com_release && m_half)));
    endtask

    task automatic cycle();
        @(posedge clk);
        #1;
        model_step();
        check_all();
    endtask

    task automatic wr(input logic pg, input logic [8:0] a, input logic [3:0] d);
        wr_en = 1'b1; wr_page = pg; wr_addr = a; wr_data = d;
        cycle();
        wr_en = 1'b0;
    endtask

    task automatic measure_hold(input int exp);
        logic [4:0] prev;
        int n;
        prev = com_idx;
        do cycle(); while (com_idx == prev);
        prev = com_idx;
        n = 0;
        do begin cycle(); n++; end while (com_idx == prev);
        chk(n == exp, "R2 hold length", 64'(n), 64'(exp));
    endtask

    task automatic check_reset();
        chk(com_idx == 5'd0, "R1 com_idx", 64'(com_idx), 64'd0);
        chk(polarity == 1'b0, "R1 polarity", 64'(polarity), 64'd0);
        chk(row_seg == 64'd0, "R1 row_seg", row_seg, 64'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) cycle();
        check_reset();
        rst_n = 1'b1;
        cycle();
        check_reset();

        // Fill both pages while the scan runs at the default rate.
        for (int a = 0; a < 1024; a++) wr(a[9], a[8:0], 4'($urandom));

        // R2: hold length at default, smallest and largest codes.
        measure_hold(16);
        rate_sel = 4'd0;  measure_hold(2);
        rate_sel = 4'd15; measure_hold(32);

        // R7: page and duty requested mid-frame wait for the boundary.
        rate_sel = 4'd1;
        while (com_idx != 5'd5) cycle();
        page_sel = 1'b1; duty_sel = 1'b1; com_release = 1'b1;
        cycle();
        chk(row_seg == exp_row(1'b0, m_row, seg_release), "R7 page held mid-frame",
            row_seg, exp_row(1'b0, m_row, seg_release));
        chk(com_hi_lcd == 1'b1, "R9 no release in full duty", 64'(com_hi_lcd), 64'd1);
        while (com_idx != 5'd0) cycle();
        chk(row_seg == exp_row(1'b1, 0, seg_release), "R7 page after boundary",
            row_seg, exp_row(1'b1, 0, seg_release));
        repeat (200) cycle();   // half duty: R3 wraps at 15

        // R6: write the hidden page while page 1 is shown.
        for (int i = 0; i < 64; i++) wr(1'b0, 9'($urandom), 4'($urandom));
        seg_release = 6'b101001;
        repeat (100) cycle();

        // Random phase.
        for (int i = 0; i < 20000; i++) begin
            int r;
            r = int'($urandom % 100);
            if (r < 30) begin
                wr_en = 1'b1; wr_page = 1'($urandom); wr_addr = 9'($urandom);
                wr_data = 4'($urandom);
            end else wr_en = 1'b0;
            if ($urandom % 100 < 1) rate_sel = 4'($urandom % 4);
            if ($urandom % 100 < 2) seg_release = 6'($urandom);
            if ($urandom % 100 < 2) com_release = 1'($urandom);
            if ($urandom % 100 < 2) page_sel = 1'($urandom);
            if ($urandom % 100 < 1) duty_sel = 1'($urandom);
            cycle();
        end
        wr_en = 1'b0;

        // R1 again: reset in the middle of operation.
        rst_n = 1'b0;
        cycle();
        check_reset();
        rst_n = 1'b1;
        seg_release = '0;
        cycle();
        check_reset();

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule